// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory. A new access starts when a base address is captured. There are two active-low start strobes for this. The cache-side strobe loads on its own. The processor-side strobe loads only while the chip-enable input is low. After a load, an active-low advance input steps the two least significant address bits through a four-beat sequence. When advance is high, the burst is suspended and the same address is presented again. The upper address bits keep the loaded value for the whole burst.

Two beat orders are available: linear, where the base is added to a beat count modulo 4, and interleaved, where the base is exclusive-ORed with the beat count. A static order-select input picks the order. Its value is captured while reset is asserted and is fixed from then on. The address output comes straight from internal registers through a small combinational map, so a load or a step shows up on the output just after the clock edge that caused it.

The sequencer has two named states. SEQ_IDLE is the state after reset, before any base has been captured. SEQ_ACTIVE is entered through the transition "start" on the first load, and it stays there through further loads ("restart") and through steps and suspends ("beat" and "hold"). Only a synchronous reset returns the block to SEQ_IDLE ("reset").

Top module: `burst_addr_seq`

## Requirements
- R1: While rst is high at a clock edge, the output word_addr becomes all zeros, the state becomes SEQ_IDLE, and the value on order_il is captured as the burst order (1 = interleaved, 0 = linear).
- R2: A clock edge with cache_start_n low loads base_addr; after that edge word_addr equals the loaded base_addr, whatever the level of chip_en_n.
- R3: A clock edge with proc_start_n low and chip_en_n low loads base_addr. When chip_en_n is high, proc_start_n has no effect, and word_addr changes only through advance.
- R4: A load takes priority over advance in the same cycle and restarts the beat count at zero, so word_addr shows the new base.
- R5: In SEQ_ACTIVE, with no load, an edge with adv_n low moves to the next beat. An edge with adv_n high leaves word_addr unchanged (suspend).
- R6: With interleaved order, word_addr[1:0] equals base[1:0] XOR the beat count. For example, base 01 gives 01, 00, 11, 10.
- R7: With linear order, word_addr[1:0] equals (base[1:0] + beat count) mod 4. For example, base 01 gives 01, 10, 11, 00.
- R8: After the fourth beat, one more advance returns word_addr to the first address of the burst.
- R9: Bits word_addr[AW-1:2] equal base_addr[AW-1:2] from the most recent load, for the whole burst.
- R10: Changes on order_il while rst is low do not change the burst order.
- R11: In SEQ_IDLE, adv_n has no effect, and word_addr stays zero until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also the window for capturing the order |
| cache_start_n | input | 1 | Cache-side start strobe, active low, not gated |
| proc_start_n | input | 1 | Processor-side start strobe, active low, gated by chip_en_n |
| chip_en_n | input | 1 | Qualified chip enable, active low, gates proc_start_n only |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| order_il | input | 1 | Burst order select, 1 interleaved, 0 linear; sampled during reset |
| base_addr | input | AW | External base address |
| word_addr | output | AW | Current burst word address |

## Verification
On every cycle, the checker confirms the reset value, the load from either strobe, that the processor strobe is ignored without chip enable, that a suspend holds the address, that the upper bits stay fixed, and that each step moves the low bits by the right amount for the captured order. Only the bench's scenarios can show the full address sequence for each of the four base values in both orders: the exact values, the return to the first address after four beats, suspends in the middle of a burst, and the order staying fixed when order_il toggles after reset. The bench's scenarios also cover the idle state ignoring advance and a load winning over an advance in the same cycle.

// File: rtl/bas_pkg.sv
package bas_pkg;

    // Width of the sequenced beat field (four beats)
    localparam int BEAT_W = 2;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;

endpackage

// File: rtl/bas_start_decode.sv
module bas_start_decode (
    input  logic cache_start_n,
    input  logic proc_start_n,
    input  logic chip_en_n,
    output logic load
);
    logic proc_ok;

    // Processor strobe is qualified by chip enable; cache strobe is not
    always_comb begin
        proc_ok = ~proc_start_n & ~chip_en_n;
        load    = ~cache_start_n | proc_ok;
    end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            count <= count + W'(1);   // natural wrap gives the four-beat return
        end
    end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
    parameter int  W        = 2,
    parameter bit  BOTH_MAP = 1'b1
) (
    input  logic         interleave,
    input  logic [W-1:0] base_lo,
    input  logic [W-1:0] count,
    output logic [W-1:0] addr_lo
);
    logic [W-1:0] lin_lo;
    logic [W-1:0] xor_lo;

    always_comb begin
        lin_lo = base_lo + count;
        xor_lo = base_lo ^ count;
    end

    generate
        if (BOTH_MAP) begin : g_sel
            always_comb addr_lo = interleave ? xor_lo : lin_lo;
        end else begin : g_lin
            logic unused_ok;
            always_comb begin
                unused_ok = interleave ^ (^xor_lo);
                addr_lo   = lin_lo;
            end
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cache_start_n,
    input  logic          proc_start_n,
    input  logic          chip_en_n,
    input  logic          adv_n,
    input  logic          order_il,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] word_addr
);
    import bas_pkg::*;

    localparam int BW = BEAT_W;
    localparam int UW = AW - BW;

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic          load;
    logic          step;
    logic          order_q;
    logic [AW-1:0] base_q;
    logic [BW-1:0] beat_cnt;
    logic [BW-1:0] low_bits;
    logic [UW-1:0] upper_bits;

    bas_start_decode u_dec (
        .cache_start_n (cache_start_n),
        .proc_start_n  (proc_start_n),
        .chip_en_n     (chip_en_n),
        .load          (load)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (load) state_d = SEQ_ACTIVE;   // start
            SEQ_ACTIVE: state_d = SEQ_ACTIVE;             // restart / beat / hold
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State register, base register, configuration capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            base_q  <= '0;
            order_q <= order_il;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q <= base_addr;
            end
        end
    end

    // Control outputs of the state machine
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   step = 1'b0;
            SEQ_ACTIVE: step = ~load & ~adv_n;
            default:    step = 1'b0;
        endcase
    end

    bas_beat_counter #(.W(BW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (load),
        .step  (step),
        .count (beat_cnt)
    );

    bas_order_map #(.W(BW), .BOTH_MAP(1'b1)) u_map (
        .interleave (order_q),
        .base_lo    (base_q[BW-1:0]),
        .count      (beat_cnt),
        .addr_lo    (low_bits)
    );

    always_comb begin
        upper_bits = base_q[AW-1:BW];
        word_addr  = {upper_bits, low_bits};
    end
endmodule

// File: rtl/bas_seq_chk.sv
module bas_seq_chk #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          cache_start_n,
    input logic          proc_start_n,
    input logic          chip_en_n,
    input logic          adv_n,
    input logic          order_q,
    input logic          active,
    input logic [AW-1:0] base_addr,
    input logic [AW-1:0] word_addr
);
    logic ld_any;
    always_comb ld_any = ~cache_start_n | (~proc_start_n & ~chip_en_n);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> word_addr == '0);

    // R2
    cache_load_chk: assert property (@(posedge clk) disable iff (rst)
        !cache_start_n |=> word_addr == $past(base_addr));

    // R3
    proc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!proc_start_n && !chip_en_n) |=> word_addr == $past(base_addr));

    // R3
    proc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_start_n && chip_en_n && adv_n) |=> $stable(word_addr));

    // R5
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_any && adv_n) |=> $stable(word_addr));

    // R9
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_any |=> $stable(word_addr[AW-1:2]));

    // R7
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ld_any && !adv_n && !order_q)
        |=> word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1));

    // R6
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ld_any && !adv_n && order_q)
        |=> word_addr[0] != $past(word_addr[0]));

    // R11
    idle_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !ld_any) |=> word_addr == '0);
endmodule

bind burst_addr_seq bas_seq_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cache_start_n (cache_start_n),
    .proc_start_n  (proc_start_n),
    .chip_en_n     (chip_en_n),
    .adv_n         (adv_n),
    .order_q       (order_q),
    .active        (state_q == bas_pkg::SEQ_ACTIVE),
    .base_addr     (base_addr),
    .word_addr     (word_addr)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cache_start_n = 1'b1;
    logic          proc_start_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_il = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] word_addr;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned cycles  = 0;

    // Reference model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt  = '0;
    logic          m_act  = 1'b0;
    logic          m_il   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    burst_addr_seq #(.AW(AW)) u0 (
        .clk           (clk),
        .rst           (rst),
        .cache_start_n (cache_start_n),
        .proc_start_n  (proc_start_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .order_il      (order_il),
        .base_addr     (base_addr),
        .word_addr     (word_addr)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic check(input string tag);
        logic [AW-1:0] e;
        e = exp_addr();
        n_tests++;
        if (word_addr !== e) begin
            n_fail++;
            $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, e);
        end
    endtask

    // Drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic c_n, input logic p_n, input logic ce_n,
                        input logic a_n, input logic [AW-1:0] b, input string tag);
        cache_start_n = c_n;
        proc_start_n  = p_n;
        chip_en_n     = ce_n;
        adv_n         = a_n;
        base_addr     = b;
        @(posedge clk);
        if (!c_n || (!p_n && !ce_n)) begin
            m_base = b;
            m_cnt  = 2'd0;
            m_act  = 1'b1;
        end else if (m_act && !a_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst      = 1'b1;
        order_il = mode;
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        m_base = '0;
        m_cnt  = 2'd0;
        m_act  = 1'b0;
        m_il   = mode;
        check("R1 reset value");
    endtask

    function automatic logic [AW-1:0] rnd_base(input logic [1:0] lo);
        logic [AW-1:0] r;
        r = AW'($urandom);
        return {r[AW-1:2], lo};
    endfunction

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
                report();
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int mode = 0; mode < 2; mode++) begin
            do_reset(mode[0]);
            // R11: advance while idle does nothing
            step(1, 1, 1, 0, rnd_base(2'd3), "R11 idle advance");
            step(1, 1, 1, 0, rnd_base(2'd1), "R11 idle advance");
            // R10: order_il toggled after reset has no effect
            order_il = ~order_il;
            for (int b = 0; b < 4; b++) begin
                string seq_tag;
                seq_tag = m_il ? "R6 interleaved beat" : "R7 linear beat";
                step(0, 1, 1, 1, rnd_base(2'(b)), "R2 cache load");
                step(1, 1, 1, 0, '0, seq_tag);
                step(1, 1, 1, 0, '0, seq_tag);
                step(1, 1, 1, 1, '0, "R5 suspend hold");
                step(1, 1, 1, 1, '0, "R5 suspend hold");
                step(1, 1, 1, 0, '0, "R10 order fixed");
                step(1, 1, 1, 0, '0, "R8 wrap to first");
                step(1, 1, 1, 0, '0, "R9 upper held");
            end
            // R3: processor strobe gated by chip enable
            step(1, 0, 1, 1, rnd_base(2'd2), "R3 gated strobe ignored");
            step(1, 0, 0, 1, rnd_base(2'd2), "R3 gated strobe loads");
            step(1, 1, 0, 0, '0, "R5 step");
            // R4: load wins over advance and clears count
            step(1, 0, 0, 0, rnd_base(2'd3), "R4 load beats advance");
            step(0, 1, 1, 0, rnd_base(2'd1), "R4 load beats advance");
            step(0, 1, 0, 1, rnd_base(2'd0), "R2 load with ce high");
            // Random mix
            for (int i = 0; i < 400; i++) begin
                logic [7:0] r;
                r = 8'($urandom);
                if (i % 37 == 0) order_il = ~order_il;
                step(r[2:0] != 3'd0, r[5:3] != 3'd0, r[6], r[7] & r[0],
                     AW'($urandom), "R5 random");
            end
        end
        report();
    end
endmodule